// File: doc/BRIEF.md
# Balanced Ternary Sequential Divider

This block divides a signed balanced ternary dividend of 2K digits by a signed divisor of K digits. It returns a K-digit quotient and a K-digit remainder. Each digit is carried on two wires. The upper wire has weight -1 and the lower wire has weight +1, so 10 means -1, 01 means +1, and both 00 and 11 mean zero. The block works one quotient digit per clock, starting from the most significant position.

The block is built around a four-state controller:

- **ST_IDLE** waits for `start_i`.
  - Transition *accept*: ST_IDLE to ST_CHECK when `start_i` is high. The operands are latched and normalised.
- **ST_CHECK** detects the signs of the divisor and the dividend. It also runs the overflow trial at digit offset K.
  - Transition *reject*: ST_CHECK to ST_IDLE, raising the zero-divisor or overflow flag with `done_o`.
  - Transition *proceed*: ST_CHECK to ST_ITER.
- **ST_ITER** handles one quotient digit per cycle. It forms the candidate W = R - q*d*3^j, where q is +1 if the partial remainder and the divisor have the same sign and -1 otherwise. The candidate is kept only when R + W has the sign of R, that is when 2|R| > |d|*3^j. Otherwise the digit is zero.
  - Transition *last*: ST_ITER to ST_CORR after position 0.
- **ST_CORR** applies the final fix-up. If the remainder is nonzero and its sign differs from the dividend's sign, the same datapath subtracts q*d once and adds q to the quotient.
  - Transition *finish*: ST_CORR to ST_IDLE with `done_o`.

Top module: `bt_divider`

## Requirements
- R1: Digit i of every vector sits at bits [2i+1:2i], with bit 2i+1 worth -1 and bit 2i worth +1. The input code 11 is accepted as zero. Outputs use only 00, 01 and 10.
- R2: After reset, `busy_o`, `done_o`, `div0_o` and `ovf_o` are 0, and `quo_o` and `rem_o` are all zero.
- R3: A `start_i` pulse while `busy_o` is high is ignored. It neither changes the running result nor shortens its latency.
- R4: For an accepted division, dividend = quotient*divisor + remainder, |remainder| < |divisor|, and the remainder is zero or has the dividend's sign.
- R5: A valid division raises `done_o` for exactly one cycle, K+2 clock edges after the edge that samples `start_i`.
- R6: `busy_o` is high from the edge that samples `start_i` until the edge that raises `done_o`, and is low while `done_o` is high.
- R7: An all-zero divisor raises `div0_o` with `done_o` one edge after the start edge. `ovf_o` stays 0 and the quotient and remainder read zero.
- R8: If 2*|dividend| > |divisor|*3^K, `ovf_o` is raised with `done_o` one edge after the start edge, and the quotient and remainder read zero. Equality is not an overflow.
- R9: Accepting a start clears both flags and both result outputs. Results and flags then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a division (sampled in idle) |
| dividend_i | input | 4*K | Dividend, 2K digits |
| divisor_i | input | 2*K | Divisor, K digits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quo_o | output | 2*K | Quotient, K digits |
| rem_o | output | 2*K | Remainder, K digits |
| div0_o | output | 1 | Divisor was zero |
| ovf_o | output | 1 | Quotient would not fit K digits |

## Verification
Each wrong internal state shows up at the ports within a fixed, short window:

- **Wrong quotient digit or sign decision.** A digit chosen in error leaves a remainder outside plus or minus half the divisor, which the single correction cannot repair. The result then breaks the identity of R4 at the same `done_o` pulse.
- **Stuck state or miscounted digit index.** These move the `done_o` edge away from K+2, or keep `busy_o` high past it. Either is visible on the first operation that follows.
- **Wrong correction direction.** This gives a remainder with the wrong sign, or a quotient off by one, on every case where the raw remainder opposes the dividend.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t T_Z = 2'b00;
    localparam trit_t T_P = 2'b01;
    localparam trit_t T_N = 2'b10;

    typedef enum logic [1:0] {
        SG_ZERO = 2'd0,
        SG_POS  = 2'd1,
        SG_NEG  = 2'd2
    } sgn_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_ITER  = 2'd2,
        ST_CORR  = 2'd3
    } state_t;

    function automatic int trit_val(trit_t t);
        return int'(t[0]) - int'(t[1]);
    endfunction

    function automatic trit_t trit_enc(int v);
        if (v > 0) begin
            return T_P;
        end else if (v < 0) begin
            return T_N;
        end
        return T_Z;
    endfunction

    function automatic trit_t trit_neg(trit_t t);
        return {t[0], t[1]};
    endfunction

    function automatic trit_t trit_norm(trit_t t);
        return (t[0] & t[1]) ? T_Z : t;
    endfunction

endpackage

// File: rtl/bt_add.sv
module bt_add
    import bt_pkg::*;
#(
    parameter int ND = 8
)
(
    input  logic [2*ND-1:0] a_i,
    input  logic [2*ND-1:0] b_i,
    input  trit_t           cin_i,
    output logic [2*ND-1:0] sum_o
);

    trit_t cy [ND+1];
    logic  unused_carry;

    assign cy[0]        = cin_i;
    assign unused_carry = ^cy[ND];

    for (genvar g = 0; g < ND; g++) begin : g_fa
        int    tot;
        trit_t c_out;
        trit_t s_out;
        always_comb begin
            tot = trit_val(a_i[2*g +: 2]) + trit_val(b_i[2*g +: 2]) + trit_val(cy[g]);
            if (tot > 1) begin
                c_out = T_P;
            end else if (tot < -1) begin
                c_out = T_N;
            end else begin
                c_out = T_Z;
            end
            s_out = trit_enc(tot - 3 * trit_val(c_out));
        end
        assign sum_o[2*g +: 2] = s_out;
        assign cy[g+1]         = c_out;
    end

endmodule

// File: rtl/bt_sign.sv
module bt_sign
    import bt_pkg::*;
#(
    parameter int ND = 8
)
(
    input  logic [2*ND-1:0] vec_i,
    output sgn_t            sign_o
);

    always_comb begin
        sign_o = SG_ZERO;
        for (int i = 0; i < ND; i++) begin
            if (vec_i[2*i] ^ vec_i[2*i+1]) begin
                sign_o = vec_i[2*i] ? SG_POS : SG_NEG;
            end
        end
    end

endmodule

// File: rtl/bt_divider.sv
module bt_divider
    import bt_pkg::*;
#(
    parameter int K = 6
)
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           start_i,
    input  logic [4*K-1:0] dividend_i,
    input  logic [2*K-1:0] divisor_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*K-1:0] quo_o,
    output logic [2*K-1:0] rem_o,
    output logic           div0_o,
    output logic           ovf_o
);

    localparam int ZD = 2 * K;
    localparam int ND = ZD + 2;
    localparam int IW = $clog2(K + 1);

    state_t           state_q, state_d;
    logic [2*ND-1:0]  rem_q;
    logic [2*K-1:0]   dvs_q;
    logic [2*K-1:0]   quo_q;
    logic [IW-1:0]    idx_q;
    sgn_t             sd_q, sz_q;

    logic [2*ND-1:0]  dsh, sub_vec, w_vec, t_vec;
    logic [4*K-1:0]   dvd_n;
    logic [2*K-1:0]   dvs_n, qinc, qsum;
    sgn_t             s_r, s_t, s_d, sd_use, s_out;
    trit_t            qd;
    logic             accept, need_fix;

    // operand normalisation: code 11 becomes 00
    always_comb begin
        for (int i = 0; i < ZD; i++) begin
            dvd_n[2*i +: 2] = trit_norm(dividend_i[2*i +: 2]);
        end
        for (int i = 0; i < K; i++) begin
            dvs_n[2*i +: 2] = trit_norm(divisor_i[2*i +: 2]);
        end
    end

    // divisor scaled by 3^idx
    always_comb begin
        dsh = '0;
        for (int i = 0; i < ND; i++) begin
            for (int m = 0; m < K; m++) begin
                if (i == m + int'(idx_q)) begin
                    dsh[2*i +: 2] = dvs_q[2*m +: 2];
                end
            end
        end
    end

    bt_sign #(.ND(ND)) u_sgn_r (.vec_i(rem_q), .sign_o(s_r));
    bt_sign #(.ND(K))  u_sgn_d (.vec_i(dvs_q), .sign_o(s_d));

    assign sd_use = (state_q == ST_CHECK) ? s_d : sd_q;

    always_comb begin
        if (s_r == SG_ZERO) begin
            qd = T_Z;
        end else if (s_r == sd_use) begin
            qd = T_P;
        end else begin
            qd = T_N;
        end
    end

    // subtrahend q*d*3^j, negated for the adder
    always_comb begin
        for (int i = 0; i < ND; i++) begin
            if (qd == T_P) begin
                sub_vec[2*i +: 2] = trit_neg(dsh[2*i +: 2]);
            end else if (qd == T_N) begin
                sub_vec[2*i +: 2] = dsh[2*i +: 2];
            end else begin
                sub_vec[2*i +: 2] = T_Z;
            end
        end
    end

    bt_add #(.ND(ND)) u_add_w (.a_i(rem_q), .b_i(sub_vec), .cin_i(T_Z), .sum_o(w_vec));
    bt_add #(.ND(ND)) u_add_t (.a_i(rem_q), .b_i(w_vec),   .cin_i(T_Z), .sum_o(t_vec));
    bt_sign #(.ND(ND)) u_sgn_t (.vec_i(t_vec), .sign_o(s_t));

    assign qinc = {{(2*K-2){1'b0}}, qd};
    bt_add #(.ND(K)) u_add_q (.a_i(quo_q), .b_i(qinc), .cin_i(T_Z), .sum_o(qsum));

    assign accept   = (s_r != SG_ZERO) && (s_t == s_r);
    assign need_fix = (s_r != SG_ZERO) && (s_r != sz_q);

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CHECK;
            ST_CHECK: state_d = ((s_d == SG_ZERO) || accept) ? ST_IDLE : ST_ITER;
            ST_ITER:  if (idx_q == '0) state_d = ST_CORR;
            ST_CORR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);

    // datapath and outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rem_q  <= '0;
            dvs_q  <= '0;
            quo_q  <= '0;
            idx_q  <= '0;
            sd_q   <= SG_ZERO;
            sz_q   <= SG_ZERO;
            done_o <= 1'b0;
            quo_o  <= '0;
            rem_o  <= '0;
            div0_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        rem_q  <= {4'b0000, dvd_n};
                        dvs_q  <= dvs_n;
                        quo_q  <= '0;
                        idx_q  <= IW'(K);
                        quo_o  <= '0;
                        rem_o  <= '0;
                        div0_o <= 1'b0;
                        ovf_o  <= 1'b0;
                    end
                end
                ST_CHECK: begin
                    sd_q <= s_d;
                    sz_q <= s_r;
                    if (s_d == SG_ZERO) begin
                        div0_o <= 1'b1;
                        done_o <= 1'b1;
                    end else if (accept) begin
                        ovf_o  <= 1'b1;
                        done_o <= 1'b1;
                    end else begin
                        idx_q <= IW'(K - 1);
                    end
                end
                ST_ITER: begin
                    if (accept) begin
                        rem_q <= w_vec;
                        quo_q[2*int'(idx_q) +: 2] <= qd;
                    end
                    if (idx_q != '0) begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                ST_CORR: begin
                    rem_o  <= need_fix ? w_vec[2*K-1:0] : rem_q[2*K-1:0];
                    quo_o  <= need_fix ? qsum : quo_q;
                    done_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic out_bad;
    always_comb begin
        out_bad = 1'b0;
        for (int i = 0; i < K; i++) begin
            if ((&quo_o[2*i +: 2]) || (&rem_o[2*i +: 2])) begin
                out_bad = 1'b1;
            end
        end
    end

    bt_sign #(.ND(K)) u_sgn_o (.vec_i(rem_o), .sign_o(s_out));

    a_r1_canonical_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !out_bad);

    a_r4_rem_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CORR) |=> ((s_out == SG_ZERO) || (s_out == sz_q)));

    a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r6_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    a_r7_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(div0_o && ovf_o));

    a_r8_ovf_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && ovf_o) |-> (quo_o == '0 && rem_o == '0));

endmodule

// File: tb/bt_divider_bench.sv
module bt_divider_bench;

    localparam int K = 6;
    localparam longint P3K = 729;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [4*K-1:0] dvd = '0;
    logic [2*K-1:0] dvs = '0;
    logic           busy, done, div0, ovf;
    logic [2*K-1:0] quo, rem;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bt_divider #(.K(K)) u_bt_divider (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .dividend_i(dvd), .divisor_i(dvs),
        .busy_o(busy), .done_o(done), .quo_o(quo), .rem_o(rem),
        .div0_o(div0), .ovf_o(ovf)
    );

    function automatic logic [4*K-1:0] enc(longint v);
        logic [4*K-1:0] r = '0;
        longint x = v;
        for (int i = 0; i < 2*K; i++) begin
            longint m = x % 3;
            if (m == 2)  m = -1;
            if (m == -2) m = 1;
            r[2*i +: 2] = (m > 0) ? 2'b01 : (m < 0) ? 2'b10 : 2'b00;
            x = (x - m) / 3;
        end
        return r;
    endfunction

    function automatic longint dec(logic [4*K-1:0] v, int nd);
        longint s = 0;
        longint w = 1;
        for (int i = 0; i < nd; i++) begin
            if (v[2*i] && !v[2*i+1]) s += w;
            else if (!v[2*i] && v[2*i+1]) s -= w;
            w *= 3;
        end
        return s;
    endfunction

    function automatic logic [4*K-1:0] scramble(logic [4*K-1:0] v);
        logic [4*K-1:0] r = v;
        for (int i = 0; i < 2*K; i++) begin
            if (r[2*i +: 2] == 2'b00 && ($urandom % 2) == 1) r[2*i +: 2] = 2'b11;
        end
        return r;
    endfunction

    function automatic bit has_bad(logic [2*K-1:0] v);
        for (int i = 0; i < K; i++) if (&v[2*i +: 2]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic longint labs(longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(longint z, longint d, bit zero11, bit poke);
        logic [4*K-1:0] ze = enc(z);
        logic [4*K-1:0] de = enc(d);
        bit e_dz = (d == 0);
        bit e_ov = !e_dz && (2 * labs(z) > labs(d) * P3K);
        longint eq = 0;
        longint er = 0;
        int n;
        logic [2*K-1:0] q_hold;
        if (!e_dz && !e_ov) begin
            eq = z / d;
            er = z - eq * d;
        end
        n = (e_dz || e_ov) ? 1 : K + 2;
        @(negedge clk);
        start = 1'b1;
        dvd = zero11 ? scramble(ze) : ze;
        dvs = zero11 ? scramble(de) [2*K-1:0] : de[2*K-1:0];
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6", "busy after start", longint'(busy), 1);
        for (int c = 1; c < n; c++) begin
            if (poke && c == 2) begin
                start = 1'b1;
                dvd = enc(1);
                dvs = enc(1) [2*K-1:0];
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done == 1'b0 && busy == 1'b1, "R5", "done early", longint'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, poke ? "R3" : "R5", "done at expected edge", longint'(done), 1);
        chk(busy == 1'b0, "R6", "busy at done", longint'(busy), 0);
        chk(div0 == e_dz, "R7", "div0 flag", longint'(div0), longint'(e_dz));
        chk(ovf == e_ov, "R8", "ovf flag", longint'(ovf), longint'(e_ov));
        chk(dec({{(2*K){1'b0}}, quo}, K) == eq, poke ? "R3" : "R4", "quotient",
            dec({{(2*K){1'b0}}, quo}, K), eq);
        chk(dec({{(2*K){1'b0}}, rem}, K) == er, zero11 ? "R1" : "R4", "remainder",
            dec({{(2*K){1'b0}}, rem}, K), er);
        chk(!has_bad(quo) && !has_bad(rem), "R1", "canonical output codes",
            longint'(has_bad(quo) || has_bad(rem)), 0);
        q_hold = quo;
        @(negedge clk);
        chk(done == 1'b0, "R5", "done single cycle", longint'(done), 0);
        chk(quo == q_hold && div0 == e_dz && ovf == e_ov, "R9", "result hold",
            dec({{(2*K){1'b0}}, quo}, K), dec({{(2*K){1'b0}}, q_hold}, K));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7193));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && div0 == 0 && ovf == 0, "R2", "reset flags",
            longint'({busy, done, div0, ovf}), 0);
        chk(quo == '0 && rem == '0, "R2", "reset results",
            dec({{(2*K){1'b0}}, quo}, K), 0);

        run(492, -25, 0, 0);
        run(-492, 25, 0, 0);
        run(492, 25, 1, 0);
        run(0, 7, 0, 0);
        run(5, 0, 0, 0);
        run(0, 0, 1, 0);
        run(729, 2, 0, 0);
        run(730, 2, 0, 0);
        run(-729, -2, 0, 0);
        run(364, 1, 0, 0);
        run(365, 1, 0, 0);
        run(132678, 364, 0, 0);
        run(-265720, -364, 0, 0);
        run(-1000, 37, 0, 1);
        run(100, 7, 1, 1);

        for (int t = 0; t < 300; t++) begin
            longint d = longint'($urandom % 729) - 364;
            longint z;
            if (t % 2 == 0 && d != 0) begin
                longint q = longint'($urandom % 601) - 300;
                longint r = longint'($urandom % labs(d));
                if ($urandom % 2 == 1) r = -r;
                z = q * d + r;
            end else begin
                z = longint'($urandom % 531441) - 265720;
            end
            run(z, d, (t % 5) == 0, (t % 7) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule